// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to thirty-two interrupt request lines and drives one active-low interrupt line to a processor. Each source carries its own settings: an enable bit, a trigger type, a 3-bit priority and a vector word. A single-cycle register bus sets these up and reads them back. The same bus acknowledges interrupts and retires them.

Software's handler reads the vector port. That read returns the vector of the best eligible source and pushes the source's priority onto a hardware nesting stack. While the handler runs, only a strictly more urgent source can pull the interrupt line low again. A write to the end-of-interrupt register pops one level. When no source is eligible, the vector port returns a programmable spurious word.

A bus access lasts one cycle: `bus_req_i` is high for one clock per access. Read data is combinational from the address, and the side effects of a read take place at the closing clock edge.

Top module: `nestirq_top`

## Requirements
- R1: After reset, every enable bit is 0, and every mode word (index 0x00+n) and vector word (index 0x20+n) reads 0. The spurious word (0x46) reads 0, `irq_n_o` is 1, and a vector read (0x44) returns 0.
- R2: Writing ones to the enable-set register (0x40) enables the sources at those bit positions (bit n is source n). Writing ones to the enable-clear register (0x41) disables them. Zero bits change nothing. The mask reads back at 0x42.
- R3: A level source follows its input through a two-stage synchroniser. Trigger code 0 (high level) is pending while the input is 1, and code 2 (low level) is pending while it is 0. A pending-clear write (0x43) has no effect on a level source.
- R4: An edge source latches its event: code 1 latches a rising edge and code 3 a falling edge. The latch holds after the input returns and is cleared by a pending-clear write with that source's bit set.
- R5: The mode word holds the trigger code in bits [1:0] and the priority in bits [6:4]. Codes 2 and 3 are accepted only for sources flagged external (default mask 0xE000_0001). On any other source such a write leaves the trigger code unchanged but still updates the priority.
- R6: Among eligible sources, the one with the highest priority wins (7 is highest). On equal priority, the lower source number wins.
- R7: A vector read returns the winner's vector word, pushes the winner's priority onto the nesting stack and clears the winner's edge latch.
- R8: A vector read with no eligible source returns the spurious word and leaves the stack unchanged.
- R9: `irq_n_o` is driven to 0 only when an enabled pending source exists whose priority is above the stack top, or when the stack is empty.
- R10: Any write to the end-of-interrupt register (0x45) pops one stack level. A write on an empty stack has no effect, so eight such writes always empty the stack.
- R11: A disabled source never drives the interrupt line, but its edge latch still captures events, which are seen once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Raw interrupt request lines |
| bus_req_i | input | 1 | Single-cycle bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_n_o | output | 1 | Active-low interrupt request to the processor |

## Verification
A stack top that is too low or too high shows up within one cycle. Either the interrupt line asserts for a source of equal priority, or it stays high after an end-of-interrupt write that should have re-armed it. A stale or lost edge latch shows up two cycles after the event as a wrong line level, and at the next vector read as a wrong or spurious vector. The bench therefore reads the line after every acknowledge and after every pop. It also uses paired sources to pin down the arbitration order.

// File: rtl/nestirq_pkg.sv
package nestirq_pkg;
  localparam int unsigned PRIO_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 7;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  localparam logic [ADDR_W-1:0] A_EN_SET  = 7'h40;
  localparam logic [ADDR_W-1:0] A_EN_CLR  = 7'h41;
  localparam logic [ADDR_W-1:0] A_EN_MASK = 7'h42;
  localparam logic [ADDR_W-1:0] A_PND_CLR = 7'h43;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 7'h44;
  localparam logic [ADDR_W-1:0] A_EOI     = 7'h45;
  localparam logic [ADDR_W-1:0] A_SPUR    = 7'h46;

  // low-level and falling-edge types need an external source
  function automatic logic trig_allowed(input trig_e t, input logic is_ext);
    return is_ext | ~t[1];
  endfunction

  function automatic logic [DATA_W-1:0] mode_word(input trig_e t,
                                                  input logic [PRIO_W-1:0] p);
    return (DATA_W'(p) << 4) | DATA_W'(t);
  endfunction

  function automatic logic beats_top(input logic [PRIO_W-1:0] p,
                                     input logic [PRIO_W-1:0] top,
                                     input logic empty);
    return empty || (p > top);
  endfunction
endpackage

// File: rtl/nestirq_src.sv
module nestirq_src
  import nestirq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  raw_i,
  input  trig_e trig_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic [1:0] sync_q;
  logic       prev_q, latch_q;
  logic       s, edge_mode, edge_evt, level_pend;

  assign s          = sync_q[1];
  assign edge_mode  = trig_i[0];
  assign edge_evt   = edge_mode & (trig_i[1] ? (~s & prev_q) : (s & ~prev_q));
  assign level_pend = trig_i[1] ? ~s : s;
  assign pend_o     = edge_mode ? latch_q : level_pend;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      prev_q <= s;
      if (!edge_mode)    latch_q <= 1'b0;
      else if (edge_evt) latch_q <= 1'b1;
      else if (clr_i)    latch_q <= 1'b0;
    end
  end

  // R4
  edge_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && clr_i && !edge_evt) |=> !latch_q);
  // R4
  edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode && latch_q && !clr_i && $stable(trig_i)) |=> latch_q);
endmodule

// File: rtl/nestirq_arb.sv
module nestirq_arb
  import nestirq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  localparam int unsigned IW = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        req_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output logic                      found_o,
  output logic [IW-1:0]             idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    // descending scan with >= lets lower numbers win ties
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] >= prio_o)) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/nestirq_nest.sv
module nestirq_nest
  import nestirq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW = $clog2(DEPTH + 1),
  localparam int unsigned SW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              pop_i,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_o
);
  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CW-1:0]     cnt_q;
  logic              full;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign top_o   = mem_q[SW'(cnt_q - CW'(1))];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full) begin
      mem_q[SW'(cnt_q)] <= push_prio_i;
      cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full);
  // R9
  nest_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !empty_o) |-> (push_prio_i > top_o));
  // R10
  depth_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> $stable(cnt_q));
  // R10
  pop_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> empty_o);
endmodule

// File: rtl/nestirq_top.sv
module nestirq_top
  import nestirq_pkg::*;
#(
  parameter int unsigned       NUM_SRC    = 32,
  parameter int unsigned       VEC_W      = 16,
  parameter int unsigned       NEST_DEPTH = 8,
  parameter logic [NUM_SRC-1:0] EXT_MASK  = 32'hE000_0001,
  localparam int unsigned      IW = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_n_o
);
  logic [NUM_SRC-1:0]        en_q, pend, elig, clr_vec, ack_vec;
  trig_e                     trig_q [NUM_SRC];
  logic [PRIO_W-1:0]         prio_q [NUM_SRC];
  logic [VEC_W-1:0]          vec_q  [NUM_SRC];
  logic [VEC_W-1:0]          spur_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic                      found, empty, ack, eoi_wr;
  logic [IW-1:0]             win_idx;
  logic [PRIO_W-1:0]         win_prio, top;
  logic                      bus_wr, bus_rd, set_wr, clr_wr, pclr_wr;

  assign bus_wr  = bus_req_i & bus_we_i;
  assign bus_rd  = bus_req_i & ~bus_we_i;
  assign set_wr  = bus_wr && bus_addr_i == A_EN_SET;
  assign clr_wr  = bus_wr && bus_addr_i == A_EN_CLR;
  assign pclr_wr = bus_wr && bus_addr_i == A_PND_CLR;
  assign eoi_wr  = bus_wr && bus_addr_i == A_EOI;
  assign ack     = bus_rd && bus_addr_i == A_VECTOR && found;
  assign ack_vec = ack ? (NUM_SRC'(1) << win_idx) : '0;
  assign clr_vec = ack_vec | (pclr_wr ? bus_wdata_i[NUM_SRC-1:0] : '0);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        en_q[i]   <= 1'b0;
        trig_q[i] <= TRIG_HIGH;
        prio_q[i] <= '0;
        vec_q[i]  <= '0;
      end else begin
        if (set_wr && bus_wdata_i[i])      en_q[i] <= 1'b1;
        else if (clr_wr && bus_wdata_i[i]) en_q[i] <= 1'b0;
        if (bus_wr && bus_addr_i == ADDR_W'(i)) begin
          prio_q[i] <= bus_wdata_i[4 +: PRIO_W];
          if (trig_allowed(trig_e'(bus_wdata_i[1:0]), EXT_MASK[i]))
            trig_q[i] <= trig_e'(bus_wdata_i[1:0]);
        end
        if (bus_wr && bus_addr_i == ADDR_W'(32 + i))
          vec_q[i] <= bus_wdata_i[VEC_W-1:0];
      end
    end

    nestirq_src u_src (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (src_i[i]),
      .trig_i (trig_q[i]),
      .clr_i  (clr_vec[i]),
      .pend_o (pend[i])
    );

    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    assign elig[i] = en_q[i] & pend[i] & beats_top(prio_q[i], top, empty);
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                             spur_q <= '0;
    else if (bus_wr && bus_addr_i == A_SPUR) spur_q <= bus_wdata_i[VEC_W-1:0];
  end

  nestirq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .req_i   (elig),
    .prio_i  (prio_flat),
    .found_o (found),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  nestirq_nest #(.DEPTH(NEST_DEPTH)) u_nest (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (ack),
    .push_prio_i (win_prio),
    .pop_i       (eoi_wr),
    .empty_o     (empty),
    .top_o       (top)
  );

  assign irq_n_o = ~found;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i[6:5] == 2'b00)
      bus_rdata_o = mode_word(trig_q[bus_addr_i[4:0]], prio_q[bus_addr_i[4:0]]);
    else if (bus_addr_i[6:5] == 2'b01)
      bus_rdata_o = DATA_W'(vec_q[bus_addr_i[4:0]]);
    else if (bus_addr_i == A_EN_MASK)
      bus_rdata_o = DATA_W'(en_q);
    else if (bus_addr_i == A_VECTOR)
      bus_rdata_o = found ? DATA_W'(vec_q[win_idx]) : DATA_W'(spur_q);
    else if (bus_addr_i == A_SPUR)
      bus_rdata_o = DATA_W'(spur_q);
  end

  // R9
  irq_above_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_n_o |-> (empty || win_prio > top));
  // R6
  win_is_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> (en_q[win_idx] && pend[win_idx]));
  // R7
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |=> !empty);
  // R2
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((en_q & $past(bus_wdata_i[NUM_SRC-1:0])) == $past(bus_wdata_i[NUM_SRC-1:0])));
  // R2
  en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((en_q & $past(bus_wdata_i[NUM_SRC-1:0])) == '0));
  // R11
  masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> irq_n_o);
endmodule

// File: tb/nestirq_tb.sv
module nestirq_top_tb_top;
  localparam int unsigned N = 32;
  localparam logic [6:0] EN_SET = 7'h40, EN_CLR = 7'h41, EN_MASK = 7'h42,
                         PND_CLR = 7'h43, VECT = 7'h44, EOI = 7'h45, SPUR = 7'h46;
  // arbitration table: {src_a, prio_a, src_b, prio_b}, both level-high
  localparam logic [31:0] ARB_TBL [6] = '{
    {8'd8,  8'd2, 8'd9,  8'd5},
    {8'd10, 8'd4, 8'd11, 8'd4},
    {8'd12, 8'd6, 8'd13, 8'd1},
    {8'd15, 8'd0, 8'd14, 8'd0},
    {8'd16, 8'd7, 8'd17, 8'd7},
    {8'd19, 8'd3, 8'd18, 8'd3}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic        irq_n;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  nestirq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_n_o(irq_n)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic cleanup();
    src = '0; settle();
    wr(EN_CLR, 32'hFFFF_FFFF);
    for (int i = 0; i < N; i++) wr(7'(i), 32'h0);
    wr(PND_CLR, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) wr(EOI, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", 32'(irq_n), 32'd1);
    rd(EN_MASK, rv); check("R1 enable mask", rv, 0);
    rd(7'h05, rv);   check("R1 mode word", rv, 0);
    rd(7'h25, rv);   check("R1 vector word", rv, 0);
    rd(VECT, rv);    check("R1 vector port", rv, 0);
    // R8 spurious word
    wr(SPUR, 32'h0000_DEAD);
    rd(VECT, rv); check("R8 spurious", rv, 32'h0000_DEAD);
    for (int i = 0; i < N; i++) wr(7'(32 + i), 32'h100 + 32'(i));
    // R2 set/clear
    wr(EN_SET, 32'h5); wr(EN_SET, 32'h0); wr(EN_CLR, 32'h4);
    rd(EN_MASK, rv); check("R2 mask", rv, 32'h1);
    wr(EN_CLR, 32'h0);
    rd(EN_MASK, rv); check("R2 zero clear", rv, 32'h1);
    cleanup();
    // R3 level high
    wr(7'd3, 32'h20); wr(EN_SET, 32'h8);
    src[3] = 1'b1; settle();
    check("R3 level high", 32'(irq_n), 0);
    wr(PND_CLR, 32'h8); @(negedge clk);
    check("R3 clear ignored", 32'(irq_n), 0);
    src[3] = 1'b0; settle();
    check("R3 level drop", 32'(irq_n), 1);
    cleanup();
    // R3 level low on external source 30
    wr(7'd30, 32'h02); wr(EN_SET, 32'h4000_0000); @(negedge clk);
    check("R3 level low", 32'(irq_n), 0);
    src[30] = 1'b1; settle();
    check("R3 level low released", 32'(irq_n), 1);
    cleanup();
    // R5 trigger legality
    wr(7'd4, 32'h53);
    rd(7'd4, rv); check("R5 internal falling refused", rv, 32'h50);
    wr(7'd4, 32'h51);
    rd(7'd4, rv); check("R5 internal rising", rv, 32'h51);
    wr(7'd31, 32'h32);
    rd(7'd31, rv); check("R5 external low", rv, 32'h32);
    // R4 rising edge latch on source 4
    wr(EN_SET, 32'h10);
    src[4] = 1'b1; repeat (3) @(negedge clk); src[4] = 1'b0; settle();
    check("R4 rising latched", 32'(irq_n), 0);
    wr(PND_CLR, 32'h10); @(negedge clk);
    check("R4 pending clear", 32'(irq_n), 1);
    // R11 disabled source still latches
    wr(EN_CLR, 32'h10);
    src[4] = 1'b1; repeat (3) @(negedge clk); src[4] = 1'b0; settle();
    check("R11 masked", 32'(irq_n), 1);
    wr(EN_SET, 32'h10); @(negedge clk);
    check("R11 seen after enable", 32'(irq_n), 0);
    cleanup();
    // R4 falling edge on external source 31, then R7 acknowledge
    wr(7'd31, 32'h03);
    src[31] = 1'b1; settle();
    wr(EN_SET, 32'h8000_0000); @(negedge clk);
    check("R4 no fall yet", 32'(irq_n), 1);
    src[31] = 1'b0; settle();
    check("R4 falling latched", 32'(irq_n), 0);
    rd(VECT, rv); check("R7 vector", rv, 32'h11F);
    check("R7 latch cleared", 32'(irq_n), 1);
    wr(EOI, 0); @(negedge clk);
    check("R10 after pop", 32'(irq_n), 1);
    cleanup();
    // R6 arbitration table
    foreach (ARB_TBL[k]) begin
      automatic int a = int'(ARB_TBL[k][31:24]);
      automatic int pa = int'(ARB_TBL[k][23:16]);
      automatic int b = int'(ARB_TBL[k][15:8]);
      automatic int pb = int'(ARB_TBL[k][7:0]);
      automatic int w = (pa > pb || (pa == pb && a < b)) ? a : b;
      wr(7'(a), 32'(pa) << 4); wr(7'(b), 32'(pb) << 4);
      wr(EN_SET, (32'd1 << a) | (32'd1 << b));
      src[a] = 1'b1; src[b] = 1'b1; settle();
      rd(VECT, rv); check("R6 winner", rv, 32'h100 + 32'(w));
      check("R9 equal prio blocked", 32'(irq_n), 1);
      cleanup();
    end
    // R9 nesting
    wr(7'd5, 32'h10); wr(7'd6, 32'h10); wr(7'd7, 32'h30);
    wr(EN_SET, 32'hE0);
    src[5] = 1'b1; src[6] = 1'b1; settle();
    rd(VECT, rv); check("R9 first ack", rv, 32'h105);
    check("R9 blocked", 32'(irq_n), 1);
    src[7] = 1'b1; settle();
    check("R9 higher preempts", 32'(irq_n), 0);
    rd(VECT, rv); check("R9 nested ack", rv, 32'h107);
    rd(VECT, rv); check("R8 nothing eligible", rv, 32'h0000_DEAD);
    wr(EOI, 0); @(negedge clk);
    check("R10 pop rearms", 32'(irq_n), 0);
    src[7] = 1'b0; settle();
    check("R9 top back to 1", 32'(irq_n), 1);
    // R10 eight pops always unlock
    src[7] = 1'b1; settle();
    rd(VECT, rv); check("R10 push again", rv, 32'h107);
    for (int i = 0; i < 8; i++) wr(EOI, 0);
    src[7] = 1'b0; settle();
    check("R10 unlocked", 32'(irq_n), 0);
    rd(VECT, rv); check("R10 empty stack", rv, 32'h105);
    cleanup();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule